// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Unit

This block is the software-facing control plane for seven DMA channels. A 32-bit register bus writes and reads, for each channel, a memory address register, a block-count register and a control register. Two shared registers are also on the bus. One holds a per-channel enable bit, and the other holds interrupt enables and completion flags.

A write to a channel's control register asks the block to start that channel. The start goes ahead only when the busy bit (bit 24) in the written value is set and the channel's bit in the shared enable register is set. When both hold, the block sends a one-cycle start pulse to an external transfer engine and marks the channel as running. The transfer engine answers with a one-cycle done pulse. On that pulse the block clears the busy bit and, if the channel's interrupt enable is set, it sets the channel's completion flag. While any flag is set, the block drives an interrupt request toward the system interrupt controller.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset every mapped register reads 0, no start pulse is driven and the interrupt request is low.
- R2: For channel n (0..6) the address register sits at offset 0x80+16n, the block-count register at 0x84+16n and the control register at 0x88+16n. The enable register sits at 0xF0. The address, block-count and enable registers read back the full 32-bit value last written to them.
- R3: A control-register write for channel n with bit 24 of the data set, while bit 4n+3 of the enable register is set, raises start bit n in the cycle after the write edge. The control register reads back the written value.
- R4: If bit 24 of the written data is clear, or enable bit 4n+3 is clear, no start pulse is issued. In that case the control register keeps the written value, including bit 24.
- R5: A start pulse lasts one cycle, and at most one start bit is high in any cycle.
- R6: A done pulse on a running channel clears bit 24 of that channel's control register and leaves its other bits unchanged. The effect is visible after that edge.
- R7: A done pulse on a channel that is not running changes no register and does not raise the interrupt request.
- R8: On completion of channel n, flag bit 24+n of the interrupt register (offset 0xF4) is set if and only if enable bit 16+n of that register is set.
- R9: A write to the interrupt register loads bits 23:0 from the data. In bits 31:24, each bit written as 1 clears the stored flag, and each bit written as 0 keeps the stored flag.
- R10: The interrupt request is high exactly while any of flag bits 31:24 is set.
- R11: Writes to unmapped offsets change no register, and reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| xfer_start | output | 7 | Per-channel one-cycle start pulse to the transfer engine |
| xfer_done | input | 7 | Per-channel one-cycle completion pulse from the transfer engine |
| dma_irq | output | 1 | Interrupt request to the system interrupt controller |

## Verification
Read data is combinational, so a register's new value can be read in the cycle after the write edge. The start pulse comes from a register loaded at the control-write edge, so it is high during the following cycle and low one cycle later. A done pulse takes effect at the edge that samples it, so the cleared busy bit, the new flag and the interrupt request can all be seen in the next cycle. The bench drives every input on the falling edge and samples on the falling edge. Each check therefore lands exactly one cycle after the edge that should produce the result. The sweep covers every channel against every combination of the written busy bit, the channel enable bit and the interrupt enable bit.

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int NCH  = 7,
  parameter int BUSY = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NCH-1:0]      xfer_start,
  input  logic [NCH-1:0]      xfer_done,
  output logic                dma_irq
);
  localparam logic [7:0] EN_OFS  = 8'hF0;
  localparam logic [7:0] IRQ_OFS = 8'hF4;
  localparam int         FLAG_LO = 24;
  localparam int         IEN_LO  = 16;

  logic [31:0]    madr [NCH];
  logic [31:0]    bcnt [NCH];
  logic [31:0]    cctl [NCH];
  logic [31:0]    en_reg;
  logic [23:0]    irq_lo;
  logic [7:0]     flags;
  logic [NCH-1:0] busy;
  logic [NCH-1:0] start_q;

  logic       in_ch;
  logic [3:0] chsel;
  logic [3:0] sub;
  assign sub   = bus_addr[3:0];
  assign chsel = bus_addr[7:4] - 4'd8;
  assign in_ch = (bus_addr[7:4] >= 4'd8) && (int'(bus_addr[7:4]) < 8 + NCH);

  logic [NCH-1:0] fin;
  logic [7:0]     set_f;
  assign fin   = xfer_done & busy;
  assign set_f = 8'(fin & irq_lo[IEN_LO +: NCH]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        madr[i] <= '0;
        bcnt[i] <= '0;
        cctl[i] <= '0;
      end
      busy    <= '0;
      start_q <= '0;
    end else begin
      start_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        if (fin[i]) begin
          cctl[i][BUSY] <= 1'b0;
          busy[i]       <= 1'b0;
        end
        if (bus_wr && in_ch && int'(chsel) == i) begin
          case (sub)
            4'h0: madr[i] <= bus_wdata;
            4'h4: bcnt[i] <= bus_wdata;
            4'h8: begin
              cctl[i] <= bus_wdata;
              if (bus_wdata[BUSY] && en_reg[4*i+3]) begin
                start_q[i] <= 1'b1;
                busy[i]    <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_reg <= '0;
      irq_lo <= '0;
      flags  <= '0;
    end else begin
      if (bus_wr && bus_addr == EN_OFS) en_reg <= bus_wdata;
      if (bus_wr && bus_addr == IRQ_OFS) begin
        irq_lo <= bus_wdata[23:0];
        flags  <= (flags & ~bus_wdata[31:FLAG_LO]) | set_f;
      end else begin
        flags  <= flags | set_f;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_ch) begin
      for (int i = 0; i < NCH; i++) begin
        if (int'(chsel) == i) begin
          case (sub)
            4'h0: bus_rdata = madr[i];
            4'h4: bus_rdata = bcnt[i];
            4'h8: bus_rdata = cctl[i];
            default: bus_rdata = '0;
          endcase
        end
      end
    end else if (bus_addr == EN_OFS) begin
      bus_rdata = en_reg;
    end else if (bus_addr == IRQ_OFS) begin
      bus_rdata = {flags, irq_lo};
    end
  end

  assign xfer_start = start_q;
  assign dma_irq    = |flags;
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
  parameter int NCH  = 7,
  parameter int BUSY = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [7:0]     bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [NCH-1:0] xfer_start,
  input logic [NCH-1:0] xfer_done,
  input logic           dma_irq,
  input logic [NCH-1:0] busy
);
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_start)); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_irq) |-> $past(|(xfer_done & busy))); // R8

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hF4 && (&bus_wdata[31:24]) && !(|xfer_done)) |=> !dma_irq); // R9

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [7:0] CA = 8'h88 + 8'(16 * g);

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start[g] |-> $past(bus_wr && bus_addr == CA && bus_wdata[BUSY])); // R3

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start[g] && !(bus_wr && bus_addr == CA)) |=> !xfer_start[g]); // R5

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done[g] && busy[g] && !(bus_wr && bus_addr == CA)) |=> !busy[g]); // R6
  end
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.NCH(NCH), .BUSY(BUSY)) u_chk (.*);

// File: tb/dma_ctl_regs_tb.sv
module dma_ctl_regs_tb;
  localparam int NCH = 7;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_wr;
  logic [7:0]     bus_addr;
  logic [31:0]    bus_wdata;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] xfer_start;
  logic [NCH-1:0] xfer_done;
  logic           dma_irq;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_ctl_regs u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic done(input int ch);
    @(negedge clk);
    xfer_done = NCH'(1) << ch;
    @(negedge clk);
    xfer_done = '0;
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      vecs++; errs++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, cv, ie_v, exp_irq;
    bit st;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; xfer_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < 3; s++) begin
        rd(8'(8'h80 + 16*c + 4*s), v);
        chk(v == 0, "R1 channel reg", v, 0);
      end
    end
    rd(8'hF0, v); chk(v == 0, "R1 enable reg", v, 0);
    rd(8'hF4, v); chk(v == 0, "R1 irq reg", v, 0);
    chk(xfer_start == 0 && dma_irq == 0, "R1 outputs", {xfer_start, dma_irq}, 0);

    // R2: address / block-count readback
    for (int c = 0; c < NCH; c++) begin
      wr(8'(8'h80 + 16*c), 32'hA000_0000 + 32'(c * 32'h0101_0101));
      wr(8'(8'h84 + 16*c), 32'h5F00_0000 ^ 32'(c));
    end
    for (int c = 0; c < NCH; c++) begin
      rd(8'(8'h80 + 16*c), v);
      chk(v == 32'hA000_0000 + 32'(c * 32'h0101_0101), "R2 address reg", v, 32'hA000_0000 + 32'(c * 32'h0101_0101));
      rd(8'(8'h84 + 16*c), v);
      chk(v == (32'h5F00_0000 ^ 32'(c)), "R2 block-count reg", v, 32'h5F00_0000 ^ 32'(c));
    end
    wr(8'hF0, 32'hDEAD_BEEF);
    rd(8'hF0, v); chk(v == 32'hDEAD_BEEF, "R2 enable reg", v, 32'hDEAD_BEEF);

    // R11: unmapped offsets
    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h8C, v); chk(v == 0, "R11 read 0x8C", v, 0);
    rd(8'hFC, v); chk(v == 0, "R11 read 0xFC", v, 0);
    rd(8'h00, v); chk(v == 0, "R11 read 0x00", v, 0);
    rd(8'h80, v); chk(v == 32'hA000_0000, "R11 ch0 address intact", v, 32'hA000_0000);
    rd(8'h88, v); chk(v == 0, "R11 ch0 control intact", v, 0);
    rd(8'hF4, v); chk(v == 0, "R11 irq intact", v, 0);

    // Sweep: channel x busy bit x channel enable x interrupt enable
    for (int c = 0; c < NCH; c++) begin
      for (int m = 0; m < 8; m++) begin
        bit b24, en, ie;
        b24 = m[0]; en = m[1]; ie = m[2];
        ie_v = ie ? (32'h1 << (16 + c)) : 32'h0;
        wr(8'hF4, 32'hFF00_0000 | ie_v);
        chk(dma_irq == 0, "R10 irq low after flag clear", 32'(dma_irq), 0);
        wr(8'hF0, en ? (32'h1 << (4*c + 3)) : (32'h0FFF_FFFF & ~(32'h1 << (4*c + 3))));
        cv = {7'd0, b24, 24'h00A5C0 | 24'(c) | (24'(m) << 8)};
        wr(8'(8'h88 + 16*c), cv);
        st = b24 && en;
        chk(xfer_start == (st ? NCH'(1) << c : NCH'(0)), st ? "R3 start pulse" : "R4 no start",
            32'(xfer_start), st ? 32'(1) << c : 0);
        rd(8'(8'h88 + 16*c), v);
        chk(v == cv, "R4 control readback", v, cv);
        @(negedge clk);
        chk(xfer_start == 0, "R5 single-cycle start", 32'(xfer_start), 0);
        done(c);
        rd(8'(8'h88 + 16*c), v);
        if (st) begin
          chk(v == (cv & ~32'h0100_0000), "R6 busy cleared", v, cv & ~32'h0100_0000);
          exp_irq = ie_v | (ie ? (32'h1 << (24 + c)) : 32'h0);
          rd(8'hF4, v);
          chk(v == exp_irq, "R8 flag on completion", v, exp_irq);
          chk(dma_irq == ie, "R10 irq follows flag", 32'(dma_irq), 32'(ie));
          if (ie) begin
            wr(8'hF4, 32'h0012_3456 | (32'hFF00_0000 & ~(32'h1 << (24 + c))));
            rd(8'hF4, v);
            chk(v == (32'h0012_3456 | (32'h1 << (24 + c))), "R9 zero keeps flag", v, 32'h0012_3456 | (32'h1 << (24 + c)));
            chk(dma_irq == 1, "R10 irq held", 32'(dma_irq), 1);
            wr(8'hF4, 32'h1 << (24 + c));
            rd(8'hF4, v);
            chk(v == 0, "R9 one clears flag", v, 0);
            chk(dma_irq == 0, "R10 irq drops", 32'(dma_irq), 0);
          end
        end else begin
          chk(v == cv, "R7 control unchanged", v, cv);
          rd(8'hF4, v);
          chk(v == ie_v, "R7 irq reg unchanged", v, ie_v);
          chk(dma_irq == 0, "R7 no irq", 32'(dma_irq), 0);
        end
        wr(8'(8'h88 + 16*c), 32'h0);
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule